// File: doc/BRIEF.md
# Power-of-two scaled FP4 block encoder

The encoder turns a stream of BF16 numbers into compact 4-bit blocks. It takes one element per beat and collects 32 of them. It then picks one shared scale for the group, a pure power of two, so that the largest magnitude in the group falls into the top binade of a 4-bit float (1 sign bit, 2 exponent bits, 1 mantissa bit). It divides every element by that scale, rounds it and clamps it to one of the eight magnitudes such a float can hold. The result leaves as a single record: an 8-bit biased exponent for the scale and 128 bits of packed codes. Each group is scaled independently, so a single large value only coarsens the resolution of its own group.

Control is a three-state machine:
- **ST_FILL** accepts input beats.
- **ST_QUANT** converts the buffered elements one per cycle through a single quantizer.
- **ST_SEND** presents the record until the consumer takes it.

The transitions are:
- *close*: ST_FILL to ST_QUANT, on the 32nd accepted element or on an element flagged as last.
- *converted*: ST_QUANT to ST_SEND, after the final slot index.
- *taken*: ST_SEND to ST_FILL, on the output handshake.

A producer may end a group early with the last flag. Slots that were never filled encode as zero.

Top module: `mx4_block_encoder`

## Requirements
- R1: A group closes on its 32nd accepted element, even when the last flag is low. Records leave in the same order as their groups arrived, one record per group.
- R2: `out_scale` is the block's largest BF16 exponent field (bits 14:7) minus 2. This is the E8M0 code with bias 127, so the scale is 2^(code-127). When that largest field is below 2, the code is 0. An all-zero block gives scale code 0 and codes of 0.
- R3: Element i of a group is stored in `out_payload[4i+3:4i]` as {sign, magnitude index}. The magnitude index 0..7 selects 0, 0.5, 1, 1.5, 2, 3, 4 or 6. The sign bit is copied from the input, so a zero result can be 0000 or 1000.
- R4: The value that is encoded is 1.mantissa × 2^(exponent field − scale code). It is rounded to the nearest magnitude in the set, and an exact midpoint goes to the even index.
- R5: A scaled value of 6 or more encodes as magnitude index 7. This includes values that would round up to 8.
- R6: An input whose exponent field is 0 (zero or subnormal) encodes as {sign, 000} and does not count toward the block maximum.
- R7: When the last flag is set on element n < 32, the group closes after n elements. Slots n..31 hold 0000, and the scale uses only the n elements received.
- R8: `in_ready` is high while filling. It is low from the cycle after a group closes until its record has been taken.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_scale` and `out_payload` stay unchanged.
- R10: The scale of a group depends only on that group's elements. An outlier in one group does not change the scale of the group that follows it.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input element is offered |
| in_ready | output | 1 | The encoder can accept an element |
| in_elem | input | 16 | BF16 element |
| in_last | input | 1 | The offered element ends the group |
| out_valid | output | 1 | A packed record is available |
| out_ready | input | 1 | The consumer takes the record |
| out_scale | output | 8 | Shared scale, biased power-of-two exponent |
| out_payload | output | 128 | 32 four-bit codes, element i at bits 4i+3:4i |

## Verification
The assertions check on every cycle:
- the output stays frozen under backpressure;
- input readiness drops once a group closes;
- a 32nd element always ends the group;
- the running block maximum never falls within a group;
- subnormal inputs never produce a nonzero magnitude;
- the element holding the block maximum always lands in the top binade.

Only the bench scenarios show that the rounding is correct. These include a sweep over every mantissa across thirteen exponents against a fixed scale, the midpoint ties, and saturation. The scenarios also cover the short-group padding, the clamp of the scale code at the bottom of the exponent range, and the independence of the scale of one group from the group before it.

// File: rtl/mx4_pkg.sv
package mx4_pkg;

    // Input element format (BF16)
    localparam int BF16_W     = 16;
    localparam int BF16_EXP_W = 8;
    localparam int BF16_MAN_W = 7;

    // Output code and scale formats
    localparam int FP4_W      = 4;
    localparam int FP4_MAG_W  = 3;
    localparam int SCALE_W    = 8;

    // Highest exponent of the 4-bit float; the block maximum lands here
    localparam int TOP_EXP    = 2;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_QUANT = 2'd1,
        ST_SEND  = 2'd2
    } enc_state_e;

endpackage

// File: rtl/mx4_block_buffer.sv
module mx4_block_buffer
    import mx4_pkg::*;
#(
    parameter int BLK_LEN = 32,
    parameter int IDX_W   = $clog2(BLK_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [BF16_W-1:0]     wr_elem,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [BF16_W-1:0]     rd_elem,
    output logic [BF16_EXP_W-1:0] max_exp
);

    localparam int EXP_LSB = BF16_MAN_W;

    logic [BF16_W-1:0]     elem_q [BLK_LEN];
    logic [BF16_EXP_W-1:0] wr_exp;

    assign wr_exp  = wr_elem[EXP_LSB +: BF16_EXP_W];
    assign rd_elem = elem_q[rd_idx];

    // Element storage; unwritten slots are masked by the reader
    always_ff @(posedge clk) begin
        if (wr_en) begin
            elem_q[wr_idx] <= wr_elem;
        end
    end

    // Running maximum of the exponent field; a zero field never raises it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_exp <= '0;
        end else if (clear) begin
            max_exp <= '0;
        end else if (wr_en && (wr_exp > max_exp)) begin
            max_exp <= wr_exp;
        end
    end

    // R2: within a group the running maximum never decreases
    a_r2_max_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> (max_exp >= $past(max_exp)));

endmodule

// File: rtl/mx4_scale_unit.sv
module mx4_scale_unit
    import mx4_pkg::*;
(
    input  logic [BF16_EXP_W-1:0] max_exp,
    output logic [SCALE_W-1:0]    scale_code
);

    localparam logic [BF16_EXP_W-1:0] SHIFT = BF16_EXP_W'(TOP_EXP);

    // Both formats use bias 127, so the shift is a plain subtraction
    always_comb begin
        if (max_exp >= SHIFT) begin
            scale_code = SCALE_W'(max_exp - SHIFT);
        end else begin
            scale_code = '0;
        end
    end

endmodule

// File: rtl/mx4_elem_quant.sv
module mx4_elem_quant
    import mx4_pkg::*;
(
    input  logic [BF16_W-1:0]  elem,
    input  logic [SCALE_W-1:0] scale_code,
    output logic [FP4_W-1:0]   code
);

    // Scaled value = 1.man * 2^d with d = exp - scale.
    // It is rounded on a grid of half units whose spacing grows by 2^max(d,0).
    logic                  sgn;
    logic [BF16_EXP_W-1:0] ex;
    logic [BF16_MAN_W-1:0] man;
    logic signed [9:0]     dlt;
    logic signed [9:0]     rsh_full;
    logic [3:0]            rsh;
    logic [1:0]            gsh;
    logic [23:0]           ext;
    logic                  rnd_up;
    logic [7:0]            units;
    logic [9:0]            halves;
    logic [FP4_MAG_W-1:0]  mag;

    always_comb begin
        sgn      = elem[BF16_W-1];
        ex       = elem[BF16_MAN_W +: BF16_EXP_W];
        man      = elem[BF16_MAN_W-1:0];
        dlt      = $signed({2'b00, ex}) - $signed({2'b00, scale_code});
        rsh_full = 10'sd6 - dlt;

        if (dlt >= 10'sd1) begin
            rsh = 4'd6;
            gsh = (dlt >= 10'sd2) ? 2'd2 : 2'd1;
        end else begin
            rsh = (rsh_full > 10'sd15) ? 4'd15 : rsh_full[3:0];
            gsh = 2'd0;
        end

        ext    = {1'b1, man, 16'b0} >> rsh;
        rnd_up = ext[15] & ((|ext[14:0]) | ext[16]);
        units  = ext[23:16] + {7'b0, rnd_up};
        halves = {2'b00, units} << gsh;

        if (ex == '0) begin
            mag = 3'd0;
        end else if (dlt > 10'sd2) begin
            mag = 3'd7;
        end else begin
            unique case (halves)
                10'd0:   mag = 3'd0;
                10'd1:   mag = 3'd1;
                10'd2:   mag = 3'd2;
                10'd3:   mag = 3'd3;
                10'd4:   mag = 3'd4;
                10'd6:   mag = 3'd5;
                10'd8:   mag = 3'd6;
                default: mag = 3'd7;
            endcase
        end

        code = {sgn, mag};
    end

endmodule

// File: rtl/mx4_block_encoder.sv
module mx4_block_encoder
    import mx4_pkg::*;
#(
    parameter int BLK_LEN = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [15:0]                  in_elem,
    input  logic                         in_last,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [7:0]                   out_scale,
    output logic [BLK_LEN*4-1:0]         out_payload
);

    localparam int IDX_W     = $clog2(BLK_LEN);
    localparam int CNT_W     = $clog2(BLK_LEN + 1);
    localparam int PAYLOAD_W = BLK_LEN * FP4_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_LEN - 1);

    enc_state_e            state_q, state_nx;
    logic [IDX_W-1:0]      wr_idx_q;
    logic [IDX_W-1:0]      rd_idx_q;
    logic [CNT_W-1:0]      fill_cnt_q;
    logic                  accept;
    logic                  blk_close;
    logic                  taken;
    logic [BF16_W-1:0]     rd_elem;
    logic [BF16_W-1:0]     q_in;
    logic [FP4_W-1:0]      q_code;
    logic [BF16_EXP_W-1:0] max_exp;
    logic [SCALE_W-1:0]    scale_code;
    logic [PAYLOAD_W-1:0]  payload_w;

    assign accept    = in_valid && in_ready;
    assign blk_close = accept && (in_last || (wr_idx_q == LAST_IDX));
    assign taken     = out_valid && out_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions: close, converted, taken
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FILL:  if (blk_close)             state_nx = ST_QUANT;
            ST_QUANT: if (rd_idx_q == LAST_IDX)  state_nx = ST_SEND;
            ST_SEND:  if (out_ready)             state_nx = ST_FILL;
            default:                             state_nx = ST_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready    = (state_q == ST_FILL);
        out_valid   = (state_q == ST_SEND);
        out_scale   = scale_code;
        out_payload = payload_w;
    end

    // Fill and convert indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx_q   <= '0;
            rd_idx_q   <= '0;
            fill_cnt_q <= '0;
        end else begin
            if (accept) begin
                wr_idx_q <= blk_close ? '0 : wr_idx_q + 1'b1;
            end
            if (blk_close) begin
                fill_cnt_q <= CNT_W'(wr_idx_q) + CNT_W'(1);
            end
            if (state_q == ST_QUANT) begin
                rd_idx_q <= (rd_idx_q == LAST_IDX) ? '0 : rd_idx_q + 1'b1;
            end
        end
    end

    mx4_block_buffer #(
        .BLK_LEN (BLK_LEN),
        .IDX_W   (IDX_W)
    ) u_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (taken),
        .wr_en   (accept),
        .wr_idx  (wr_idx_q),
        .wr_elem (in_elem),
        .rd_idx  (rd_idx_q),
        .rd_elem (rd_elem),
        .max_exp (max_exp)
    );

    mx4_scale_unit u_scale (
        .max_exp    (max_exp),
        .scale_code (scale_code)
    );

    // Slots past the received count are fed as zero
    assign q_in = (CNT_W'(rd_idx_q) < fill_cnt_q) ? rd_elem : '0;

    mx4_elem_quant u_quant (
        .elem       (q_in),
        .scale_code (scale_code),
        .code       (q_code)
    );

    // One code register per slot, loaded when the convert index reaches it
    for (genvar gi = 0; gi < BLK_LEN; gi++) begin : g_slot
        logic [FP4_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if ((state_q == ST_QUANT) && (rd_idx_q == IDX_W'(gi))) begin
                slot_q <= q_code;
            end
        end
        assign payload_w[gi*FP4_W +: FP4_W] = slot_q;
    end

    // R1: the 32nd element always ends the group
    a_r1_full_block_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (wr_idx_q == LAST_IDX)) |=> (state_q == ST_QUANT));

    // R8: no input is accepted once a group has closed
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        blk_close |=> !in_ready);

    // R9: the record is frozen under backpressure
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_scale) && $stable(out_payload)));

    // R6: zero-exponent inputs never give a nonzero magnitude
    a_r6_subnormal_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_QUANT) && (q_in[14:7] == 8'd0)) |-> (q_code[2:0] == 3'd0));

    // R2: the element holding the block maximum lands in the top binade (4 or 6)
    a_r2_max_top_binade: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_QUANT) && (q_in[14:7] == max_exp) && (max_exp >= 8'd2))
            |-> (q_code[2:0] >= 3'd6));

endmodule

// File: tb/mx4_block_encoder_bench.sv
module mx4_block_encoder_bench;

    localparam int BLK = 32;
    localparam int PW  = BLK * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_elem = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [7:0]    out_scale;
    logic [PW-1:0] out_payload;

    always #5 clk = ~clk;

    mx4_block_encoder #(.BLK_LEN(BLK)) u_mx4_block_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_elem     (in_elem),
        .in_last     (in_last),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_scale   (out_scale),
        .out_payload (out_payload)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    int            n_sent = 0;
    int            n_recv = 0;
    bit            stall_mode = 1'b0;
    logic [15:0]   blk [BLK];
    logic [7:0]    exp_scale_q [$];
    logic [PW-1:0] exp_pay_q [$];
    string         exp_tag_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic real pow2(input int e);
        real r = 1.0;
        if (e >= 0) for (int k = 0; k < e; k++) r = r * 2.0;
        else        for (int k = 0; k < -e; k++) r = r / 2.0;
        return r;
    endfunction

    function automatic real mag_val(input int j);
        case (j)
            0: return 0.0;  1: return 0.5;  2: return 1.0;  3: return 1.5;
            4: return 2.0;  5: return 3.0;  6: return 4.0;  default: return 6.0;
        endcase
    endfunction

    // Nearest magnitude index, ties to the even index, saturating at 6
    function automatic int nearest_idx(input real v);
        real lo, hi, mid;
        if (v >= 6.0) return 7;
        for (int j = 0; j < 7; j++) begin
            lo = mag_val(j);
            hi = mag_val(j + 1);
            if (v < hi) begin
                mid = (lo + hi) / 2.0;
                if (v < mid) return j;
                if (v > mid) return j + 1;
                return (j % 2 == 0) ? j : j + 1;
            end
        end
        return 7;
    endfunction

    function automatic void model_block(input int n, input string tag);
        int            emax = 0;
        int            s;
        int            ex;
        int            mi;
        real           v;
        logic [PW-1:0] pay = '0;
        for (int i = 0; i < n; i++)
            if (int'(blk[i][14:7]) > emax) emax = int'(blk[i][14:7]);
        s = (emax >= 2) ? emax - 2 : 0;
        for (int i = 0; i < n; i++) begin
            ex = int'(blk[i][14:7]);
            if (ex == 0) mi = 0;
            else begin
                v  = (1.0 + real'(blk[i][6:0]) / 128.0) * pow2(ex - s);
                mi = nearest_idx(v);
            end
            pay[i*4 +: 4] = {blk[i][15], 3'(mi)};
        end
        exp_scale_q.push_back(8'(s));
        exp_pay_q.push_back(pay);
        exp_tag_q.push_back(tag);
    endfunction

    // Entered and left at one time unit after a rising edge
    task automatic push(input logic [15:0] d, input bit last, input int gap);
        for (int k = 0; k < gap; k++) begin
            @(posedge clk); #1;
        end
        in_valid = 1'b1;
        in_elem  = d;
        in_last  = last;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_block(input int n, input bit use_last, input int gap_max,
                              input string tag);
        model_block(n, tag);
        n_sent++;
        for (int i = 0; i < n; i++)
            push(blk[i], use_last && (i == n - 1),
                 (gap_max > 0) ? $urandom_range(0, gap_max) : 0);
    endtask

    // Consumer backpressure
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = stall_mode ? ($urandom_range(0, 3) == 0) : 1'b1;
        end
    end

    // Output monitor, sampling at the falling edge
    initial begin : monitor
        bit            prev_stall = 1'b0;
        logic [7:0]    ps = '0;
        logic [PW-1:0] pp = '0;
        logic [7:0]    es;
        logic [PW-1:0] ep;
        string         tg;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_stall)
                    check(out_valid && (out_scale == ps) && (out_payload == pp),
                          "R9", "record held under backpressure", int'(out_scale), int'(ps));
                if (out_valid)
                    check(!in_ready, "R8", "in_ready while record pending", int'(in_ready), 0);
                if (out_valid && out_ready) begin
                    n_recv++;
                    if (exp_scale_q.size() == 0) begin
                        check(1'b0, "R1", "unexpected record", n_recv, n_sent);
                    end else begin
                        es = exp_scale_q.pop_front();
                        ep = exp_pay_q.pop_front();
                        tg = exp_tag_q.pop_front();
                        check(out_scale == es, "R2", $sformatf("scale (%s)", tg),
                              int'(out_scale), int'(es));
                        for (int i = 0; i < BLK; i++)
                            check(out_payload[i*4 +: 4] == ep[i*4 +: 4], tg,
                                  $sformatf("R3 code slot %0d", i),
                                  int'(out_payload[i*4 +: 4]), int'(ep[i*4 +: 4]));
                    end
                end
                prev_stall = out_valid && !out_ready;
                ps = out_scale;
                pp = out_payload;
            end
        end
    end

    task automatic run_all();
        int m;
        int e;
        int nn;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R11", "out_valid after reset", int'(out_valid), 0);
        check(in_ready, "R11", "in_ready after reset", int'(in_ready), 1);
        @(posedge clk); #1;

        // R4: every mantissa over thirteen exponents against scale code 128
        for (int ee = 118; ee <= 130; ee++)
            for (int sg = 0; sg < 2; sg++)
                for (int m0 = 0; m0 < 128; m0 += 31) begin
                    blk[0] = 16'h4100;
                    for (int i = 1; i < BLK; i++) begin
                        m = m0 + i - 1;
                        blk[i] = (m < 128) ? {1'(sg), 8'(ee), 7'(m)} : 16'h0000;
                    end
                    send_block(BLK, (m0 % 2) == 1, 0, "R4");
                end

        // R5: scaled values from 7 up to just under 8 saturate
        for (int i = 0; i < BLK; i++) blk[i] = {1'(i % 2), 8'd130, 7'(96 + i)};
        send_block(BLK, 1'b0, 0, "R5");

        // R2: all-zero group, then a group whose largest exponent field is 1
        for (int i = 0; i < BLK; i++) blk[i] = 16'h0000;
        send_block(BLK, 1'b0, 0, "R2");
        for (int i = 0; i < BLK; i++) blk[i] = {1'(i % 2), 8'd1, 7'(i * 4)};
        send_block(BLK, 1'b1, 0, "R2");

        // R6: subnormals beside a small normal, then subnormals only
        for (int i = 0; i < BLK; i++) blk[i] = {1'(i % 3 == 0), 8'd0, 7'(i + 1)};
        blk[9] = {1'b0, 8'd5, 7'd33};
        send_block(BLK, 1'b0, 0, "R6");
        for (int i = 0; i < BLK; i++) blk[i] = {1'(i % 2), 8'd0, 7'(127 - i)};
        send_block(BLK, 1'b0, 0, "R6");

        // R7: short groups closed by the last flag, then a full one
        for (int i = 0; i < BLK; i++) blk[i] = {1'b0, 8'(125 + i % 4), 7'(i * 3)};
        send_block(5, 1'b1, 0, "R7");
        blk[0] = 16'hC0C0;
        send_block(1, 1'b1, 0, "R7");
        for (int i = 0; i < BLK; i++) blk[i] = {1'b1, 8'(120 + i % 5), 7'(i)};
        send_block(BLK, 1'b0, 0, "R7");

        // R10: an outlier group followed by a group of small values
        for (int i = 0; i < BLK; i++) blk[i] = {1'b0, 8'(120 + i % 5), 7'(i * 2)};
        blk[7] = {1'b0, 8'd200, 7'd5};
        send_block(BLK, 1'b0, 0, "R10");
        for (int i = 0; i < BLK; i++) blk[i] = {1'(i % 2), 8'(120 + i % 5), 7'(i * 2)};
        send_block(BLK, 1'b0, 0, "R10");

        // R3: random groups, lengths, bubbles and backpressure
        stall_mode = 1'b1;
        for (int b = 0; b < 150; b++) begin
            nn = ($urandom_range(0, 3) == 0) ? $urandom_range(1, BLK) : BLK;
            for (int i = 0; i < BLK; i++) begin
                e = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(100, 140);
                blk[i] = {1'($urandom_range(0, 1)), 8'(e), 7'($urandom_range(0, 127))};
            end
            send_block(nn, (nn < BLK) ? 1'b1 : 1'($urandom_range(0, 1)), 2, "R3");
        end
        stall_mode = 1'b0;

        while (exp_scale_q.size() != 0) @(posedge clk);
        repeat (5) @(posedge clk);
        check(n_recv == n_sent, "R1", "record count", n_recv, n_sent);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d records expected %0d", n_recv, n_sent);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule